// File: doc/BRIEF.md
# Cascadable Prescaled Reload Timer Bank

This block holds a bank of up-counting timer channels (four channels of 16 bits by default) behind a simple register bus. Each channel has three things: a reload value, a control word and a live counter. A running channel adds one to its counter on each tick. The tick comes from one of two sources. The first is its own power-of-two divider of the system clock. The second, in cascade mode, is the overflow of the channel just below it. When the counter steps past its top value it is loaded again from the reload value. The channel then passes an overflow strobe to its upper neighbour and, if enabled, raises a one-cycle interrupt pulse.

Software programs a channel by writing its reload value and then writing a control word with the enable bit set. The counter is loaded only when the enable bit rises or when the counter overflows. Changing the reload value never disturbs a count in progress. The bus has no handshake:
- A write completes in the cycle `bus_we` is high.
- Read data is a combinational function of `bus_addr`.
- No back-pressure exists.

Top module: `tmr_bank`

## Requirements
- R1: Control bits [1:0] select the tick rate of a non-cascaded channel. Code 0 gives one increment per cycle, code 1 one per 64 cycles, code 2 one per 256 cycles and code 3 one per 1024 cycles. After an enable rising edge, the first increment with code 1 lands 64 cycles after the enabling write edge.
- R2: A running, non-cascaded channel with code 0 increments its counter by exactly one on every clock edge.
- R3: Control bit 2 set on a channel above channel 0 makes it ignore its divider. It then increments once on each clock edge at which the channel below it overflows.
- R4: Only control bits 7, 6, 2, 1 and 0 (mask 0x00C7) are stored. A control read returns these bits in place with all other bits zero. Bit 7 is the channel enable and bit 6 the interrupt enable.
- R5: A write to a channel's count/reload address stores the reload value only. The live counter continues as if no write had taken place.
- R6: A control write that raises the enable bit loads the counter with the current reload value at that edge. Counting proceeds from there.
- R7: On the edge at which a ticking counter holds 0xFFFF, the counter is loaded with the reload value. This gives an overflow period of (0x10000 − reload) ticks.
- R8: Channel 0 in cascade mode has no count source, and its counter holds still.
- R9: Clearing the enable bit freezes the counter at the value it has reached. A later enable rising edge reloads it from the reload value.
- R10: The interrupt bit of a channel is high during the single cycle after each overflow edge, and only if bit 6 was set. The overflow strobe to the next channel is produced whether or not bit 6 is set.
- R11: After reset all counters, reload values and control words read as zero, and no interrupt is asserted.
- R12: A control write that changes the prescale code restarts that channel's divider phase. The next tick then comes a full new period after the write edge.
- R13: Address layout: `bus_addr` = {channel, sel}. When sel = 0 the address is count (read) and reload (write); when sel = 1 it is the control word. Read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | CH_W+1 (3) | {channel, sel} register address |
| bus_wdata | input | CNT_W (16) | Write data |
| bus_rdata | output | CNT_W (16) | Read data for `bus_addr` |
| irq | output | N_CH (4) | Per-channel one-cycle overflow interrupt pulses |

## Verification
The bench builds the bank with its default parameters: four channels of 16 bits and a 10-bit divider phase. With four channels, a three-deep cascade chain above channel 0 can be exercised, and the channel 0 cascade corner case is reachable. Random reload values are biased close to 0xFFFF and the divide-by-one code is favoured. This makes overflows, reloads, back-to-back interrupt pulses and cascade ticks happen within a few cycles, while the divide-by-64 code is timed directly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned PRE_SHIFT_MAX = 10;

  typedef struct packed {
    logic       en;
    logic       irq_en;
    logic       cascade;
    logic [1:0] presc;
  } tmr_ctrl_t;

  function automatic logic [3:0] presc_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd0;
      2'd1:    return 4'd6;
      2'd2:    return 4'd8;
      default: return 4'd10;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PH_W = tmr_pkg::PRE_SHIFT_MAX
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [3:0] shift,
  output logic       tick
);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] lim;

  always_comb begin
    lim = '0;
    for (int i = 0; i < PH_W; i++) begin
      if (i < int'(shift)) lim[i] = 1'b1;
    end
  end

  assign tick = (phase_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= tick ? '0 : phase_q + 1'b1;
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |=> (phase_q <= $past(lim)) || $past(restart)); // R1

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PH_W      = PRE_SHIFT_MAX,
  parameter bit          HAS_LOWER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_ctrl_t        ctrl,
  input  logic [CNT_W-1:0] reload,
  input  logic             start,
  input  logic             phase_clr,
  input  logic             lower_ovf,
  output logic             ovf,
  output logic             irq,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             pre_tick;
  logic             src_tick;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  tmr_prescaler #(.PH_W(PH_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.en && !ctrl.cascade),
    .restart (phase_clr),
    .shift   (presc_shift(ctrl.presc)),
    .tick    (pre_tick)
  );

  assign src_tick = ctrl.cascade ? (lower_ovf && HAS_LOWER) : pre_tick;
  assign tick     = ctrl.en && src_tick;
  assign ovf      = tick && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= ovf && ctrl.irq_en;
      if (start || ovf) begin
        cnt_q <= reload;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign count = cnt_q;
  assign irq   = irq_q;

  AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == $past(reload)); // R6

  AST_FREEZE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !start) |=> $stable(cnt_q)); // R9

  AST_IRQ_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(cnt_q) == CNT_MAX) && $past(ctrl.en) && $past(ctrl.irq_en)
              && (cnt_q == $past(reload))); // R10

  generate
    if (!HAS_LOWER) begin : g_first
      AST_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && ctrl.cascade && !start) |=> $stable(cnt_q)); // R8
    end
  endgenerate

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned ADDR_W = CH_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [CNT_W-1:0]           bus_wdata,
  output logic [CNT_W-1:0]           bus_rdata,
  input  logic [N_CH-1:0][CNT_W-1:0] counts,
  output tmr_ctrl_t [N_CH-1:0]       ctrl,
  output logic [N_CH-1:0][CNT_W-1:0] reload,
  output logic [N_CH-1:0]            start,
  output logic [N_CH-1:0]            phase_clr
);

  logic [CH_W-1:0] ch_sel;
  logic            sel_ctl;
  logic            ch_ok;
  tmr_ctrl_t       wr_ctrl;

  assign ch_sel  = bus_addr[ADDR_W-1:1];
  assign sel_ctl = bus_addr[0];
  assign ch_ok   = int'(ch_sel) < int'(N_CH);

  assign wr_ctrl.en      = bus_wdata[7];
  assign wr_ctrl.irq_en  = bus_wdata[6];
  assign wr_ctrl.cascade = bus_wdata[2];
  assign wr_ctrl.presc   = bus_wdata[1:0];

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic hit_ctl;
      logic hit_rel;
      assign hit_ctl = bus_we && sel_ctl && ch_ok && (int'(ch_sel) == c);
      assign hit_rel = bus_we && !sel_ctl && ch_ok && (int'(ch_sel) == c);

      assign start[c]     = hit_ctl && wr_ctrl.en && !ctrl[c].en;
      assign phase_clr[c] = hit_ctl && (start[c] || (wr_ctrl.presc != ctrl[c].presc));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ctrl[c]   <= '0;
          reload[c] <= '0;
        end else begin
          if (hit_ctl) ctrl[c]   <= wr_ctrl;
          if (hit_rel) reload[c] <= bus_wdata;
        end
      end

      AST_RELOAD_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rel |=> $stable(ctrl[c])); // R5
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (ch_ok) begin
      if (sel_ctl) begin
        bus_rdata[7]   = ctrl[ch_sel].en;
        bus_rdata[6]   = ctrl[ch_sel].irq_en;
        bus_rdata[2]   = ctrl[ch_sel].cascade;
        bus_rdata[1:0] = ctrl[ch_sel].presc;
      end else begin
        bus_rdata = counts[ch_sel];
      end
    end
  end

  AST_CTRL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctl |-> (bus_rdata[CNT_W-1:8] == '0) && (bus_rdata[5:3] == 3'b000)); // R4

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PH_W  = PRE_SHIFT_MAX,
  localparam int unsigned CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned ADDR_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [N_CH-1:0]   irq
);

  tmr_ctrl_t [N_CH-1:0]       ctrl;
  logic [N_CH-1:0][CNT_W-1:0] reload;
  logic [N_CH-1:0][CNT_W-1:0] counts;
  logic [N_CH-1:0]            start;
  logic [N_CH-1:0]            phase_clr;
  logic [N_CH-1:0]            ovf;
  logic [N_CH-1:0]            lower;

  tmr_regs #(.N_CH(N_CH), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .counts    (counts),
    .ctrl      (ctrl),
    .reload    (reload),
    .start     (start),
    .phase_clr (phase_clr)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_tmr
      if (c == 0) begin : g_src0
        assign lower[c] = 1'b0;
      end else begin : g_srcn
        assign lower[c] = ovf[c-1];
      end

      tmr_channel #(
        .CNT_W     (CNT_W),
        .PH_W      (PH_W),
        .HAS_LOWER (c != 0)
      ) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl[c]),
        .reload    (reload[c]),
        .start     (start[c]),
        .phase_clr (phase_clr[c]),
        .lower_ovf (lower[c]),
        .ovf       (ovf[c]),
        .irq       (irq[c]),
        .count     (counts[c])
      );

      if (c != 0) begin : g_casc_chk
        AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
          (ctrl[c].en && ctrl[c].cascade && !start[c] && !ovf[c-1]) |=> $stable(counts[c])); // R3
      end
    end
  endgenerate

endmodule

// File: tb/test_tmr_bank.sv
module test_tmr_bank;

  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tmr_bank i_tmr_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // reference model written from the requirements
  logic [15:0] m_cnt [NC];
  logic [15:0] m_rel [NC];
  logic [15:0] m_ctl [NC];
  int          m_ph  [NC];
  logic [3:0]  m_irq;

  function automatic int sh_of(input logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 6;
      2'd2: return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic [15:0] m_read(input logic [2:0] a);
    return a[0] ? m_ctl[a[2:1]] : m_cnt[a[2:1]];
  endfunction

  always @(posedge clk) begin
    logic [15:0] n_cnt [NC];
    int          n_ph  [NC];
    logic [3:0]  n_irq;
    logic        lov;
    lov = 1'b0;
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_cnt[c] = '0; m_rel[c] = '0; m_ctl[c] = '0; m_ph[c] = 0;
      end
      m_irq = '0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        logic en, casc, pt, tk, ov;
        int lim;
        en   = m_ctl[c][7];
        casc = m_ctl[c][2];
        lim  = (1 << sh_of(m_ctl[c][1:0])) - 1;
        pt   = (m_ph[c] == lim);
        tk   = en && (casc ? (c > 0 && lov) : pt);
        ov   = tk && (m_cnt[c] == 16'hFFFF);
        n_cnt[c] = ov ? m_rel[c] : (tk ? m_cnt[c] + 16'd1 : m_cnt[c]);
        n_ph[c]  = (en && !casc) ? (pt ? 0 : m_ph[c] + 1) : m_ph[c];
        n_irq[c] = ov && m_ctl[c][6];
        lov = ov;
      end
      if (bus_we) begin
        int c;
        c = int'(bus_addr[2:1]);
        if (!bus_addr[0]) begin
          m_rel[c] = bus_wdata;
        end else begin
          logic [15:0] w;
          w = bus_wdata & 16'h00C7;
          if (w[7] && !m_ctl[c][7]) n_cnt[c] = m_rel[c];
          if ((w[7] && !m_ctl[c][7]) || (w[1:0] != m_ctl[c][1:0])) n_ph[c] = 0;
          m_ctl[c] = w;
        end
      end
      for (int c = 0; c < NC; c++) begin
        m_cnt[c] = n_cnt[c];
        m_ph[c]  = n_ph[c];
      end
      m_irq = n_irq;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    void'($urandom(32'h1F2E3D4C));
    step(3);
    rst_n = 1'b1;
    step(1);

    // R11 reset state, R13 layout
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check(v == 16'h0, "R11 reset read", v, 16'h0);
    end
    check(irq == 4'h0, "R11 reset irq", {12'h0, irq}, 16'h0);

    // R4 control mask on channel 1
    wr(3'd3, 16'hFF7F);
    rd(3'd3, v);
    check(v == 16'h0047, "R4 control mask", v, 16'h0047);
    wr(3'd3, 16'h0000);

    // R5 reload write while idle leaves counter
    wr(3'd0, 16'h1234);
    rd(3'd0, v);
    check(v == 16'h0000, "R5 reload idle", v, 16'h0000);

    // R6 enable rise loads, R2 one per cycle
    wr(3'd1, 16'h0080);
    rd(3'd0, v);
    check(v == 16'h1234, "R6 load on enable", v, 16'h1234);
    step(10);
    rd(3'd0, v);
    check(v == 16'h123E, "R2 divide by one", v, 16'h123E);

    // R5 reload write while running
    wr(3'd0, 16'hFFFE);
    rd(3'd0, v2);
    check(v2 == v + 16'd1, "R5 reload running", v2, v + 16'd1);

    // R9 freeze on disable
    wr(3'd1, 16'h0000);
    rd(3'd0, v);
    step(5);
    rd(3'd0, v2);
    check(v2 == v, "R9 freeze", v2, v);

    // R9 re-enable reloads, R7 wrap, R10 pulse
    wr(3'd1, 16'h00C0);
    rd(3'd0, v);
    check(v == 16'hFFFE, "R9 reload on re-enable", v, 16'hFFFE);
    step(1);
    rd(3'd0, v);
    check(v == 16'hFFFF, "R7 reach top", v, 16'hFFFF);
    check(irq[0] == 1'b0, "R10 no early irq", {15'h0, irq[0]}, 16'h0);
    step(1);
    rd(3'd0, v);
    check(v == 16'hFFFE, "R7 wrap reload", v, 16'hFFFE);
    check(irq[0] == 1'b1, "R10 irq pulse", {15'h0, irq[0]}, 16'h1);
    step(1);
    check(irq[0] == 1'b0, "R10 pulse one cycle", {15'h0, irq[0]}, 16'h0);

    // R8 channel 0 cascade holds
    wr(3'd1, 16'h0084);
    rd(3'd0, v);
    step(20);
    rd(3'd0, v2);
    check(v2 == v, "R8 ch0 cascade hold", v2, v);
    check(irq[0] == 1'b0, "R8 ch0 no irq", {15'h0, irq[0]}, 16'h0);
    wr(3'd1, 16'h0000);

    // R1 divide by 64 on channel 2
    wr(3'd4, 16'h0010);
    wr(3'd5, 16'h0081);
    step(63);
    rd(3'd4, v);
    check(v == 16'h0010, "R1 before 64th cycle", v, 16'h0010);
    step(1);
    rd(3'd4, v);
    check(v == 16'h0011, "R1 at 64th cycle", v, 16'h0011);
    wr(3'd5, 16'h0000);

    // R10 irq gated by bit 6, back-to-back pulses
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'h0080);
    for (int i = 0; i < 4; i++) begin
      step(1);
      check(irq[3] == 1'b0, "R10 gated off", {15'h0, irq[3]}, 16'h0);
    end
    wr(3'd7, 16'h00C0);
    step(1);
    check(irq[3] == 1'b1, "R10 gated on", {15'h0, irq[3]}, 16'h1);
    step(1);
    check(irq[3] == 1'b1, "R10 consecutive", {15'h0, irq[3]}, 16'h1);
    wr(3'd7, 16'h0000);
    step(2);

    // random traffic against the model: R1 R2 R3 R7 R10 R12
    for (int i = 0; i < 6000; i++) begin
      logic [2:0] a;
      check(irq == m_irq, "R3 R7 R10 model irq", {12'h0, irq}, {12'h0, m_irq});
      a = 3'($urandom % 8);
      rd(a, v);
      check(v == m_read(a), "R1 R2 R3 R12 R13 model read", v, m_read(a));
      if ($urandom % 8 == 0) begin
        logic [15:0] d;
        a = 3'($urandom % 8);
        if (!a[0]) begin
          d = ($urandom % 2 == 0) ? (16'hFFF0 | 16'($urandom % 16)) : 16'($urandom);
        end else begin
          d = 16'($urandom);
          if ($urandom % 4 != 0) d[1:0] = 2'b00;
          if ($urandom % 3 == 0) d[2] = 1'b1;
        end
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      end
      @(negedge clk);
      bus_we = 1'b0;
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule